// File: doc/BRIEF.md
# Stereo Limiting Gain Controller

The block limits the level of a stereo audio stream by lowering a shared volume code. On every sample strobe it scales each incoming channel sample by that channel's current gain code and registers the scaled result. From the scaled value it also finds an overshoot band, which is one of: below threshold, at or above a selectable threshold, above full scale, at or above twice full scale, or at or above four times full scale. When either channel reaches the threshold, a single shared gain target is lowered. The size of the step depends on a programmable step mode and on the worse of the two overshoot bands.

Each channel's applied gain follows the shared target in one of two ways:

- **Immediate mode.** Zero-cross detection is disabled, and both channels take the target in the same sample period. The step is then fixed at one code.
- **Zero-cross mode.** A channel takes the pending target at its own zero crossing, or when its own timeout counter expires. A channel whose scaled output is above full scale drops by one code at once and does not wait.

The block only ever lowers gain. Raising gain again is the job of a separate stage.

Top module: `alc_limiter`

## Requirements
- R1: After reset both gain codes equal GAIN_INIT and both sample outputs are 0.
- R2: On a strobe each output takes the value `(sample * gain) >>> GAIN_FRAC`, saturated to the signed W-bit range. The gain used is the channel's gain before that strobe's update. Without a strobe no output or gain changes.
- R3: While the enable input is 0, strobes never change either gain code.
- R4: The threshold select 0, 1, 2 or 3 sets a magnitude threshold of about -2.5, -4.1, -6.0 or -8.5 dB of full scale. With W=16 these are 24571, 20437, 16422 and 12315. Limiting starts when the scaled magnitude is equal to or greater than the selected threshold.
- R5: With zero-cross detection disabled, every strobe on which either channel reaches the threshold lowers both gains by exactly one code in that strobe, whatever the step mode.
- R6: In zero-cross mode the step is looked up from the step mode and the worse of the two bands. The bands are listed as (threshold, above FS, >= 2*FS, >= 4*FS). Mode 0 gives 1,1,1,1. Mode 1 gives 2,2,2,2. Mode 2 gives 2,4,4,8. Mode 3 gives 1,2,4,8. Gains never rise.
- R7: In zero-cross mode a channel takes the shared target when its input sample is zero, or when the sign bit of its input sample differs from that of its previous input sample. The previous sign is 0 after reset. A channel that sees no crossing keeps its gain.
- R8: In zero-cross mode a channel also takes the target on the (128 << timeout select)-th strobe since reset or since its last update.
- R9: In zero-cross mode, a channel whose scaled magnitude exceeds 32767 (for W=16) and that has no crossing on that strobe drops by one code on that strobe. It never drops below the target.
- R10: Target and gains saturate at 0 and never wrap. With gain 0 the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | One-cycle strobe per sample period |
| left_i | input | W | Left input sample, signed |
| right_i | input | W | Right input sample, signed |
| cfg_en_i | input | 1 | Limiter enable |
| cfg_thr_i | input | 2 | Threshold select |
| cfg_step_i | input | 2 | Step mode select |
| cfg_zc_off_i | input | 1 | 1 = immediate mode, 0 = zero-cross mode |
| cfg_tmo_i | input | 2 | Zero-cross timeout select |
| gain_l_o | output | GAIN_W | Applied left gain code |
| gain_r_o | output | GAIN_W | Applied right gain code |
| left_o | output | W | Scaled, saturated left sample |
| right_o | output | W | Scaled, saturated right sample |

## Verification
The bench builds the block with GAIN_FRAC=5 and GAIN_INIT=160, which gives a starting gain of five times. With that gain a 16-bit input can reach every band up to four times full scale, so each entry of the step table can be reached from one sample. The higher gain also lets a long run of overloaded samples, none of them crossing zero, drive the target down to its floor at 0. The channel's own gain meanwhile steps down by only one code per sample. Keeping the default timeout base of 128 puts both of the shortest timeouts within a few hundred strobes.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [2:0] {
    BAND_NONE = 3'd0,
    BAND_THR  = 3'd1,
    BAND_FS   = 3'd2,
    BAND_FS6  = 3'd3,
    BAND_FS12 = 3'd4
  } band_e;

  // step size in gain codes for a step mode and overshoot band
  function automatic logic [3:0] step_of(input logic [1:0] mode, input band_e band);
    logic [3:0] s;
    s = 4'd0;
    if (band != BAND_NONE) begin
      unique case (mode)
        2'd0: s = 4'd1;
        2'd1: s = 4'd2;
        2'd2: begin
          unique case (band)
            BAND_THR:  s = 4'd2;
            BAND_FS12: s = 4'd8;
            default:   s = 4'd4;
          endcase
        end
        default: begin
          unique case (band)
            BAND_THR:  s = 4'd1;
            BAND_FS:   s = 4'd2;
            BAND_FS6:  s = 4'd4;
            default:   s = 4'd8;
          endcase
        end
      endcase
    end
    return s;
  endfunction

  // linear threshold: full scale times a Q16 fraction of -2.5/-4.1/-6.0/-8.5 dB
  function automatic longint thr_calc(input int w, input int sel);
    longint q;
    longint fs;
    case (sel)
      0:       q = 49145;
      1:       q = 40877;
      2:       q = 32846;
      default: q = 24631;
    endcase
    fs = (longint'(1) <<< (w - 1)) - 1;
    return (fs * q) >>> 16;
  endfunction

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det
  import alc_pkg::*;
#(
  parameter int W         = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6
) (
  input  logic [W-1:0]      sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [1:0]        thr_sel_i,
  output logic [W-1:0]      out_o,
  output band_e             band_o
);

  localparam int PW = W + GAIN_W + 1;
  localparam logic [PW-1:0] FS_MAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [PW-1:0] FS_NEG = FS_MAX + 1'b1;
  localparam logic [PW-1:0] LIM6   = {{(PW-W-1){1'b0}}, 1'b1, {W{1'b0}}};
  localparam logic [PW-1:0] LIM12  = {{(PW-W-2){1'b0}}, 1'b1, {(W+1){1'b0}}};
  localparam logic [PW-1:0] THR_0  = PW'(thr_calc(W, 0));
  localparam logic [PW-1:0] THR_1  = PW'(thr_calc(W, 1));
  localparam logic [PW-1:0] THR_2  = PW'(thr_calc(W, 2));
  localparam logic [PW-1:0] THR_3  = PW'(thr_calc(W, 3));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic        [PW-1:0] mag;
  logic        [PW-1:0] thr;

  always_comb begin
    prod   = $signed(sample_i) * $signed({1'b0, gain_i});
    scaled = prod >>> GAIN_FRAC;
    mag    = scaled[PW-1] ? PW'(-scaled) : PW'(scaled);
  end

  always_comb begin
    unique case (thr_sel_i)
      2'd0:    thr = THR_0;
      2'd1:    thr = THR_1;
      2'd2:    thr = THR_2;
      default: thr = THR_3;
    endcase
  end

  always_comb begin
    if (mag >= LIM12)      band_o = BAND_FS12;
    else if (mag >= LIM6)  band_o = BAND_FS6;
    else if (mag > FS_MAX) band_o = BAND_FS;
    else if (mag >= thr)   band_o = BAND_THR;
    else                   band_o = BAND_NONE;
  end

  always_comb begin
    if (!scaled[PW-1] && mag > FS_MAX)     out_o = {1'b0, {(W-1){1'b1}}};
    else if (scaled[PW-1] && mag > FS_NEG) out_o = {1'b1, {(W-1){1'b0}}};
    else                                   out_o = scaled[W-1:0];
  end

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int GAIN_W    = 8,
  parameter int GAIN_INIT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  band_e             band_l_i,
  input  band_e             band_r_i,
  input  logic [1:0]        step_mode_i,
  input  logic              zc_off_i,
  output logic [GAIN_W-1:0] target_nxt_o
);

  logic [GAIN_W-1:0] target_q;
  logic [GAIN_W-1:0] step;
  band_e             band_max;

  always_comb begin
    band_max = (band_l_i > band_r_i) ? band_l_i : band_r_i;
    if (zc_off_i) step = GAIN_W'(band_max != BAND_NONE);
    else          step = GAIN_W'(step_of(step_mode_i, band_max));
    target_nxt_o = (target_q > step) ? target_q - step : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     target_q <= GAIN_W'(GAIN_INIT);
    else if (tick_i) target_q <= target_nxt_o;
  end

endmodule

// File: rtl/alc_ch_apply.sv
module alc_ch_apply
  import alc_pkg::*;
#(
  parameter int W         = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_INIT = 64,
  parameter int TMO_BASE  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              en_i,
  input  logic [W-1:0]      sample_i,
  input  logic              zc_off_i,
  input  logic [1:0]        tmo_sel_i,
  input  band_e             band_i,
  input  logic [GAIN_W-1:0] target_nxt_i,
  output logic [GAIN_W-1:0] gain_o
);

  localparam int CNT_W = $clog2(TMO_BASE * 8);

  logic              prev_msb_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim;
  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_dec;
  logic [GAIN_W-1:0] ov_gain;
  logic              zc;
  logic              apply;
  logic              overload;

  always_comb begin
    lim      = CNT_W'((TMO_BASE << tmo_sel_i) - 1);
    zc       = (sample_i == '0) || (sample_i[W-1] != prev_msb_q);
    apply    = zc_off_i || zc || (cnt_q == lim);
    overload = (band_i >= BAND_FS);
    gain_dec = (gain_q != '0) ? gain_q - 1'b1 : '0;
    ov_gain  = (gain_dec > target_nxt_i) ? gain_dec : target_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_msb_q <= 1'b0;
      cnt_q      <= '0;
      gain_q     <= GAIN_W'(GAIN_INIT);
    end else if (valid_i) begin
      prev_msb_q <= sample_i[W-1];
      if (en_i) begin
        if (apply) begin
          gain_q <= target_nxt_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (overload) gain_q <= ov_gain;
        end
      end
    end
  end

  assign gain_o = gain_q;

endmodule

// File: rtl/alc_limiter.sv
module alc_limiter
  import alc_pkg::*;
#(
  parameter int W         = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int GAIN_INIT = 64,
  parameter int TMO_BASE  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [W-1:0]      left_i,
  input  logic [W-1:0]      right_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_thr_i,
  input  logic [1:0]        cfg_step_i,
  input  logic              cfg_zc_off_i,
  input  logic [1:0]        cfg_tmo_i,
  output logic [GAIN_W-1:0] gain_l_o,
  output logic [GAIN_W-1:0] gain_r_o,
  output logic [W-1:0]      left_o,
  output logic [W-1:0]      right_o
);

  localparam int NCH = 2;

  logic [W-1:0]      smp_in  [NCH];
  logic [W-1:0]      smp_sc  [NCH];
  logic [W-1:0]      smp_q   [NCH];
  logic [GAIN_W-1:0] gain    [NCH];
  band_e             band    [NCH];
  logic [GAIN_W-1:0] target_nxt;
  logic              tick;

  assign smp_in[0] = left_i;
  assign smp_in[1] = right_i;
  assign tick      = smp_valid_i && cfg_en_i;

  alc_gain_ctrl #(
    .GAIN_W   (GAIN_W),
    .GAIN_INIT(GAIN_INIT)
  ) u_gain_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .band_l_i    (band[0]),
    .band_r_i    (band[1]),
    .step_mode_i (cfg_step_i),
    .zc_off_i    (cfg_zc_off_i),
    .target_nxt_o(target_nxt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    alc_level_det #(
      .W        (W),
      .GAIN_W   (GAIN_W),
      .GAIN_FRAC(GAIN_FRAC)
    ) u_det (
      .sample_i (smp_in[c]),
      .gain_i   (gain[c]),
      .thr_sel_i(cfg_thr_i),
      .out_o    (smp_sc[c]),
      .band_o   (band[c])
    );

    alc_ch_apply #(
      .W        (W),
      .GAIN_W   (GAIN_W),
      .GAIN_INIT(GAIN_INIT),
      .TMO_BASE (TMO_BASE)
    ) u_apply (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (smp_valid_i),
      .en_i        (cfg_en_i),
      .sample_i    (smp_in[c]),
      .zc_off_i    (cfg_zc_off_i),
      .tmo_sel_i   (cfg_tmo_i),
      .band_i      (band[c]),
      .target_nxt_i(target_nxt),
      .gain_o      (gain[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          smp_q[c] <= '0;
      else if (smp_valid_i) smp_q[c] <= smp_sc[c];
    end
  end

  assign gain_l_o = gain[0];
  assign gain_r_o = gain[1];
  assign left_o   = smp_q[0];
  assign right_o  = smp_q[1];

endmodule

// File: rtl/alc_limiter_chk.sv
module alc_limiter_chk #(
  parameter int W      = 16,
  parameter int GAIN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              cfg_en_i,
  input logic              cfg_zc_off_i,
  input logic [GAIN_W-1:0] gain_l_o,
  input logic [GAIN_W-1:0] gain_r_o,
  input logic [W-1:0]      left_o,
  input logic [W-1:0]      right_o
);

  assert_hold_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(left_o) && $stable(right_o) && $stable(gain_l_o) && $stable(gain_r_o));

  assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !cfg_en_i) |=> $stable(gain_l_o) && $stable(gain_r_o));

  assert_equal_gains_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && cfg_en_i && cfg_zc_off_i) |=> (gain_l_o == gain_r_o));

  assert_unit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && cfg_en_i && cfg_zc_off_i) |=>
      (({1'b0, gain_l_o} + 1'b1) >= {1'b0, $past(gain_l_o)}));

  assert_no_rise_l_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> gain_l_o <= $past(gain_l_o));

  assert_no_rise_r_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> gain_r_o <= $past(gain_r_o));

endmodule

bind alc_limiter alc_limiter_chk #(
  .W     (W),
  .GAIN_W(GAIN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .cfg_en_i    (cfg_en_i),
  .cfg_zc_off_i(cfg_zc_off_i),
  .gain_l_o    (gain_l_o),
  .gain_r_o    (gain_r_o),
  .left_o      (left_o),
  .right_o     (right_o)
);

// File: tb/tb_alc_limiter.sv
module tb_alc_limiter;

  localparam int W      = 16;
  localparam int GAIN_W = 8;
  localparam int FRAC   = 5;
  localparam int INIT   = 160;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              smp_valid_i = 1'b0;
  logic [W-1:0]      left_i = '0;
  logic [W-1:0]      right_i = '0;
  logic              cfg_en_i = 1'b1;
  logic [1:0]        cfg_thr_i = 2'd0;
  logic [1:0]        cfg_step_i = 2'd0;
  logic              cfg_zc_off_i = 1'b0;
  logic [1:0]        cfg_tmo_i = 2'd3;
  logic [GAIN_W-1:0] gain_l_o;
  logic [GAIN_W-1:0] gain_r_o;
  logic [W-1:0]      left_o;
  logic [W-1:0]      right_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alc_limiter #(
    .W        (W),
    .GAIN_W   (GAIN_W),
    .GAIN_FRAC(FRAC),
    .GAIN_INIT(INIT),
    .TMO_BASE (128)
  ) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_thr_i   (cfg_thr_i),
    .cfg_step_i  (cfg_step_i),
    .cfg_zc_off_i(cfg_zc_off_i),
    .cfg_tmo_i   (cfg_tmo_i),
    .gain_l_o    (gain_l_o),
    .gain_r_o    (gain_r_o),
    .left_o      (left_o),
    .right_o     (right_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni       = 1'b0;
    smp_valid_i  = 1'b0;
    left_i       = '0;
    right_i      = '0;
    cfg_en_i     = 1'b1;
    cfg_thr_i    = 2'd0;
    cfg_step_i   = 2'd0;
    cfg_zc_off_i = 1'b0;
    cfg_tmo_i    = 2'd3;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int l, input int r);
    @(negedge clk);
    left_i      = W'(l);
    right_i     = W'(r);
    smp_valid_i = 1'b1;
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 gain_l", int'(gain_l_o), INIT);
    chk("R1 gain_r", int'(gain_r_o), INIT);
    chk("R1 left", int'($signed(left_o)), 0);
    chk("R1 right", int'($signed(right_o)), 0);
  endtask

  task automatic t_scale();
    do_reset();
    push(1000, -1000);
    chk("R2 left scaled", int'($signed(left_o)), 5000);
    chk("R2 right scaled", int'($signed(right_o)), -5000);
    left_i  = W'(30000);
    right_i = W'(30000);
    repeat (3) @(negedge clk);
    chk("R2 left held", int'($signed(left_o)), 5000);
    chk("R2 gain held", int'(gain_l_o), INIT);
    push(-32768, 0);
    chk("R2 negative saturation", int'($signed(left_o)), -32768);
  endtask

  task automatic t_immediate();
    do_reset();
    cfg_zc_off_i = 1'b1;
    cfg_step_i   = 2'd2;
    push(5000, 100);
    chk("R5 left out", int'($signed(left_o)), 25000);
    chk("R5 gain_l step", int'(gain_l_o), 159);
    chk("R5 gain_r step", int'(gain_r_o), 159);
    push(30000, 100);
    chk("R2 positive saturation", int'($signed(left_o)), 32767);
    chk("R5 gain_l unit on overload", int'(gain_l_o), 158);
    chk("R5 gain_r unit on overload", int'(gain_r_o), 158);
  endtask

  task automatic t_disable();
    do_reset();
    cfg_en_i     = 1'b0;
    cfg_zc_off_i = 1'b1;
    push(30000, 30000);
    push(0, 0);
    chk("R3 gain_l", int'(gain_l_o), INIT);
    chk("R3 gain_r", int'(gain_r_o), INIT);
  endtask

  task automatic t_thresholds();
    do_reset();
    cfg_zc_off_i = 1'b1;
    cfg_thr_i    = 2'd0;
    push(4200, 0);
    chk("R4 sel0 below", int'(gain_l_o), 160);
    cfg_thr_i = 2'd1;
    push(4200, 0);
    chk("R4 sel1 above", int'(gain_l_o), 159);
    cfg_thr_i = 2'd2;
    push(3000, 0);
    chk("R4 sel2 below", int'(gain_l_o), 159);
    cfg_thr_i = 2'd3;
    push(3000, 0);
    chk("R4 sel3 above", int'(gain_l_o), 158);
  endtask

  task automatic step_case(input int mode, input int lin, input int step);
    int exp_l;
    do_reset();
    cfg_step_i = 2'(mode);
    push(lin, 100);
    exp_l = (lin * INIT / (1 << FRAC) > 32767) ? INIT - 1 : INIT;
    chk($sformatf("R9 mode%0d in%0d gain_l", mode, lin), int'(gain_l_o), exp_l);
    chk($sformatf("R7 mode%0d in%0d gain_r waits", mode, lin), int'(gain_r_o), INIT);
    push(0, 0);
    chk($sformatf("R6 mode%0d in%0d gain_l", mode, lin), int'(gain_l_o), INIT - step);
    chk($sformatf("R6 mode%0d in%0d gain_r", mode, lin), int'(gain_r_o), INIT - step);
  endtask

  task automatic t_steps();
    step_case(0, 5000, 1);
    step_case(0, 15000, 1);
    step_case(1, 5000, 2);
    step_case(1, 15000, 2);
    step_case(2, 5000, 2);
    step_case(2, 7000, 4);
    step_case(2, 15000, 4);
    step_case(2, 30000, 8);
    step_case(3, 5000, 1);
    step_case(3, 7000, 2);
    step_case(3, 15000, 4);
    step_case(3, 30000, 8);
  endtask

  task automatic t_crossing();
    do_reset();
    cfg_step_i = 2'd1;
    push(5000, 5000);
    chk("R7 no crossing", int'(gain_l_o), INIT);
    push(-100, 100);
    chk("R7 left crossing", int'(gain_l_o), 158);
    chk("R7 right waits", int'(gain_r_o), INIT);
    chk("R2 left uses old gain", int'($signed(left_o)), -500);
    push(-100, -100);
    chk("R7 right crossing", int'(gain_r_o), 158);
  endtask

  task automatic timeout_case(input int sel);
    int n;
    n = 128 << sel;
    do_reset();
    cfg_step_i = 2'd1;
    cfg_tmo_i  = 2'(sel);
    push(5000, 5000);
    for (int i = 0; i < n - 2; i++) push(100, 100);
    chk($sformatf("R8 sel%0d before expiry", sel), int'(gain_l_o), INIT);
    push(100, 100);
    chk($sformatf("R8 sel%0d at expiry gain_l", sel), int'(gain_l_o), 158);
    chk($sformatf("R8 sel%0d at expiry gain_r", sel), int'(gain_r_o), 158);
  endtask

  task automatic t_floor();
    do_reset();
    cfg_step_i = 2'd3;
    for (int i = 0; i < 22; i++) push(30000, 100);
    chk("R9 overload walk gain_l", int'(gain_l_o), 138);
    chk("R9 quiet channel gain_r", int'(gain_r_o), INIT);
    push(0, 0);
    chk("R10 floor gain_l", int'(gain_l_o), 0);
    chk("R10 floor gain_r", int'(gain_r_o), 0);
    push(30000, 30000);
    chk("R10 no wrap gain_l", int'(gain_l_o), 0);
    chk("R10 zero gain output", int'($signed(left_o)), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_scale();
    t_immediate();
    t_disable();
    t_thresholds();
    t_steps();
    t_crossing();
    timeout_case(0);
    timeout_case(1);
    t_floor();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule